// File: doc/BRIEF.md
# LED matrix column-scan driver

This block refreshes a multiplexed LED dot matrix with 12 row lines and up to 16 column lines. A processor loads the picture one column at a time. It writes a 20-bit instruction word and pulses a write strobe. A 4-bit field in the word names the target column, and the low 12 bits hold that column's row pattern. The block keeps each column's pattern in a small frame store, one entry per implemented column.

A second, independent process lights the columns in turn. A free-running power-of-two divider makes a one-cycle step pulse. With the default 15-bit divider and a 50 MHz clock, the step rate is about 1526 Hz, or about 0.66 ms per column. On each step, the active column moves to the next one and wraps after the last implemented column. Exactly one column select is driven at a time. The row outputs carry the stored pattern of that column. Select and row data are both registered, so they change on the same clock edge.

An active-low asynchronous reset blanks the display at once. It clears the frame store and the row outputs, and it parks the scan on column 0.

Top module: `led_matrix_scan`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls, `col_sel` equals one-hot column 0 (value 1) and `row_drive` is all zero. The frame store is cleared.
- R2: A clock edge with `instr_wr` high stores `instr_word[11:0]` as the pattern of the column whose number is in `instr_word[15:12]`.
- R3: Bits `instr_word[19:16]` have no effect on what is stored or displayed.
- R4: A write whose column field is `NUM_COLS` or larger changes no stored pattern.
- R5: The scan steps once every 2^`DIV_BITS` clock cycles. The first step, from column 0 to column 1, happens on the 2^`DIV_BITS`-th rising edge after reset is released. Between steps, `col_sel` holds.
- R6: A step from column `NUM_COLS`-1 goes to column 0.
- R7: `col_sel` is one-hot at all times, with bit i high when column i is active.
- R8: `row_drive` shows the stored pattern of the active column. It changes on the same edge as `col_sel`, and it changes at no other time unless a write arrives.
- R9: A write to the active column shows on `row_drive` from the edge that captures it, and the scan sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_wr | input | 1 | Write strobe for the instruction word |
| instr_word | input | 20 | Column number in [15:12], row pattern in [11:0], [19:16] ignored |
| col_sel | output | NUM_COLS | One-hot column select |
| row_drive | output | NUM_ROWS | Row pattern of the active column |

## Verification
The bench builds the block with a 3-bit divider and 5 columns. A step then comes every 8 cycles and a full scan takes 40 cycles, so many wraps and many step-edge collisions with writes fit in a short run. With only 5 columns, the column numbers 5 to 15 in the 4-bit field fall outside the store, which exercises the discard path. Writes aimed at the column being shown, and random writes that land on step cycles, test the same-edge bypass into the row register.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
    // Instruction word layout, shared by the write path and the checker
    localparam int INSTR_W   = 20;
    localparam int COL_LSB   = 12;
    localparam int COL_FW    = 4;
    localparam int ROW_FW    = 12;
    localparam int MAX_COLS  = 1 << COL_FW;
endpackage

// File: rtl/led_scan_divider.sv
module led_scan_divider #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    output logic scan_tick
);
    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    // terminal count of the free-running counter
    assign scan_tick = &st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/led_scan_sequencer.sv
module led_scan_sequencer #(
    parameter int NUM_COLS = 16,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_tick,
    output logic [CW-1:0]       col_next,
    output logic [NUM_COLS-1:0] col_sel
);
    localparam logic [CW-1:0] LAST_COL = CW'(NUM_COLS - 1);

    typedef struct packed {
        logic [CW-1:0]       col;
        logic [NUM_COLS-1:0] sel;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scan_tick) begin
            if (st_q.col == LAST_COL) st_d.col = '0;
            else                      st_d.col = st_q.col + 1'b1;
        end
        for (int i = 0; i < NUM_COLS; i++) begin
            st_d.sel[i] = (st_d.col == CW'(i));
        end
    end

    assign col_next = st_d.col;
    assign col_sel  = st_q.sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.col <= '0;
            st_q.sel <= NUM_COLS'(1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/led_scan_frame.sv
module led_scan_frame #(
    parameter int NUM_COLS = 16,
    parameter int NUM_ROWS = 12,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [led_scan_pkg::COL_FW-1:0]  wr_col,
    input  logic [NUM_ROWS-1:0]              wr_row,
    input  logic [CW-1:0]                    rd_col,
    output logic [NUM_ROWS-1:0]              row_out
);
    import led_scan_pkg::*;

    typedef struct packed {
        logic [NUM_COLS-1:0][NUM_ROWS-1:0] frame;
        logic [NUM_ROWS-1:0]               row;
    } frame_state_t;

    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // column numbers past the store match no entry and are dropped
        for (int i = 0; i < NUM_COLS; i++) begin
            if (wr_en && (wr_col == COL_FW'(i))) st_d.frame[i] = wr_row;
        end
        // read after the write so a hit on the shown column is seen at once
        st_d.row = '0;
        for (int i = 0; i < NUM_COLS; i++) begin
            if (rd_col == CW'(i)) st_d.row = st_d.frame[i];
        end
    end

    assign row_out = st_q.row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan #(
    parameter int NUM_COLS = 16,
    parameter int NUM_ROWS = 12,
    parameter int DIV_BITS = 15,
    localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_wr,
    input  logic [19:0]         instr_word,
    output logic [NUM_COLS-1:0] col_sel,
    output logic [NUM_ROWS-1:0] row_drive
);
    import led_scan_pkg::*;

    logic                scan_tick;
    logic [CW-1:0]       col_next;
    logic [COL_FW-1:0]   wr_col;
    logic [NUM_ROWS-1:0] wr_row;
    logic [3:0]          instr_unused;

    assign wr_col       = instr_word[COL_LSB +: COL_FW];
    assign wr_row       = instr_word[NUM_ROWS-1:0];
    assign instr_unused = instr_word[INSTR_W-1:COL_LSB+COL_FW];

    led_scan_divider #(
        .DIV_BITS (DIV_BITS)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick)
    );

    led_scan_sequencer #(
        .NUM_COLS (NUM_COLS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .col_next  (col_next),
        .col_sel   (col_sel)
    );

    led_scan_frame #(
        .NUM_COLS (NUM_COLS),
        .NUM_ROWS (NUM_ROWS)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (instr_wr),
        .wr_col  (wr_col),
        .wr_row  (wr_row),
        .rd_col  (col_next),
        .row_out (row_drive)
    );
endmodule

// File: rtl/led_matrix_scan_chk.sv
module led_matrix_scan_chk #(
    parameter int NUM_COLS = 16,
    parameter int NUM_ROWS = 12,
    parameter int DIV_BITS = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic                instr_wr,
    input logic [19:0]         instr_word,
    input logic [NUM_COLS-1:0] col_sel,
    input logic [NUM_ROWS-1:0] row_drive,
    input logic                scan_tick
);
    logic [DIV_BITS-1:0] gap_q;
    logic                wr_on_shown;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         gap_q <= '0;
        else if (scan_tick) gap_q <= '0;
        else                gap_q <= gap_q + 1'b1;
    end

    always_comb begin
        wr_on_shown = 1'b0;
        for (int i = 0; i < NUM_COLS; i++) begin
            if (instr_wr && !scan_tick && (instr_word[15:12] == 4'(i)) && col_sel[i])
                wr_on_shown = 1'b1;
        end
    end

    assert_tick_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |-> (&gap_q));

    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scan_tick) |-> $stable(col_sel));

    assert_sel_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_tick) && !$past(col_sel[NUM_COLS-1])) |-> (col_sel == ($past(col_sel) << 1)));

    assert_sel_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_tick) && $past(col_sel[NUM_COLS-1])) |-> col_sel[0]);

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_sel) == 1);

    assert_row_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(instr_wr) && !$past(scan_tick)) |-> $stable(row_drive));

    assert_write_shown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on_shown |=> (row_drive == $past(instr_word[NUM_ROWS-1:0])));
endmodule

bind led_matrix_scan led_matrix_scan_chk #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .DIV_BITS (DIV_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_wr   (instr_wr),
    .instr_word (instr_word),
    .col_sel    (col_sel),
    .row_drive  (row_drive),
    .scan_tick  (scan_tick)
);

// File: tb/led_matrix_scan_tb.sv
module led_matrix_scan_tb;
    localparam int NC     = 5;
    localparam int NR     = 12;
    localparam int DB     = 3;
    localparam int PERIOD = 1 << DB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_wr = 1'b0;
    logic [19:0]   instr_word = '0;
    logic [NC-1:0] col_sel;
    logic [NR-1:0] row_drive;

    int            n_cmp = 0;
    int            n_bad = 0;
    string         tag = "R1";

    // reference model state
    int            m_cnt;
    int            m_col;
    logic [NR-1:0] m_frame [16];
    logic [NR-1:0] m_row;

    always #5 clk = ~clk;

    led_matrix_scan #(.NUM_COLS(NC), .NUM_ROWS(NR), .DIV_BITS(DB)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_wr   (instr_wr),
        .instr_word (instr_word),
        .col_sel    (col_sel),
        .row_drive  (row_drive)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_col = 0;
            m_row = '0;
            for (int i = 0; i < 16; i++) m_frame[i] = '0;
        end else begin
            bit step;
            step  = (m_cnt == PERIOD - 1);
            m_cnt = (m_cnt + 1) % PERIOD;
            if (instr_wr && (int'(instr_word[15:12]) < NC))
                m_frame[instr_word[15:12]] = instr_word[11:0];
            if (step) m_col = (m_col + 1) % NC;
            m_row = m_frame[m_col];
        end
    end

    task automatic check_now();
        logic [NC-1:0] exp_sel;
        exp_sel = NC'(1) << m_col;
        n_cmp++;
        if (col_sel !== exp_sel || row_drive !== m_row) begin
            n_bad++;
            $display("FAIL %s: sel=%b row=%h expected sel=%b row=%h",
                     tag, col_sel, row_drive, exp_sel, m_row);
        end
    endtask

    task automatic cyc(input logic wr, input logic [19:0] w);
        @(negedge clk);
        check_now();
        instr_wr   = wr;
        instr_word = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 20'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        #23;
        tag = "R1";
        check_now();
        @(negedge clk);
        rst_n = 1'b1;

        // R5 R6 R7 R8: free scan over several wraps
        tag = "R5";
        idle(3 * NC * PERIOD);

        // R2: load every column
        tag = "R2";
        for (int c = 0; c < NC; c++) begin
            cyc(1'b1, {4'h0, 4'(c), 12'(12'h5A0 + c * 37)});
            cyc(1'b0, 20'h0);
        end
        idle(NC * PERIOD + 4);

        // R3: upper bits set must not matter
        tag = "R3";
        for (int c = 0; c < NC; c++) begin
            cyc(1'b1, {4'hF, 4'(c), 12'(12'h0C3 ^ (c * 91))});
        end
        idle(NC * PERIOD + 4);

        // R4: column numbers past the store are discarded
        tag = "R4";
        for (int c = NC; c < 16; c++) cyc(1'b1, {4'h0, 4'(c), 12'hFFF});
        idle(NC * PERIOD + 4);

        // R9: writes aimed at the column on display
        tag = "R9";
        for (int k = 0; k < 60; k++) begin
            cyc(1'b1, {4'h3, 4'(m_col), 12'($urandom)});
            cyc(1'b0, 20'h0);
        end

        // R6 R8: random traffic, including step-edge collisions
        tag = "R8";
        for (int k = 0; k < 1200; k++) begin
            cyc(1'($urandom), 20'($urandom));
        end

        // R1: asynchronous reset in mid-cycle
        tag = "R1";
        @(negedge clk);
        instr_wr = 1'b0;
        #2 rst_n = 1'b0;
        #1 check_now();
        idle(3);
        rst_n = 1'b1;
        tag = "R6";
        idle(2 * NC * PERIOD);

        summary();
        $finish;
    end
endmodule